// File: doc/BRIEF.md
# PTP Offset-Driven Frequency Servo

This block closes the frequency loop of a local time counter that tracks a remote time source. Each Sync event brings two timestamps: the host's Sync time and the local time captured when that Sync arrived. The block subtracts them to get the phase error and produces a signed correction for the counter's per-cycle increment.

The correction has two parts. The proportional (coarse) part is the error shifted right by a programmable amount. The integral (fine) part is a saturating running sum of the error shifted right by a second programmable amount. Each part has its own enable. A small shift gives a fast loop that can ring. A large shift settles slowly but stays stable. The output changes only on Sync events, so it stays constant between them.

Top module: `ptp_freq_servo`

## Requirements
- R1: The phase error is `host_ts - local_ts` taken modulo 2^TS_W and read as a signed two's-complement number of TS_W bits, in fractional-nanosecond units.
- R2: When `gain_en[0]` is 1, the proportional term is the error arithmetically shifted right (rounding toward minus infinity) by `coarse_shift` (0..15). When `gain_en[0]` is 0, this term is zero.
- R3: When `gain_en[1]` is 1, each Sync adds the error arithmetically shifted right by `fine_shift` (0..15) into the ACC_W-bit integral register. Between Syncs the register holds its value.
- R4: On each Sync, `adj_value` becomes the proportional term plus the integral register value after the current Sync has been added.
- R5: The integral register saturates at +(2^(ACC_W-1)-1) and -2^(ACC_W-1) and never wraps.
- R6: While `gain_en[1]` is 0, the integral register is cleared every cycle, so the integral term starts again from zero when the path is re-enabled.
- R7: `adj_valid` is a one-cycle pulse, high in the cycle after each cycle with `sync_valid` high and low at all other times.
- R8: `adj_value` keeps its value in every cycle that does not follow a `sync_valid`.
- R9: While `rst` is high, and after it falls until the first Sync, `adj_value` is 0 and `adj_valid` is 0.
- R10: With `gain_en` = 0, every Sync produces `adj_value` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_valid | input | 1 | One-cycle strobe: a Sync timestamp pair is present |
| host_ts | input | TS_W (40) | Host Sync timestamp, fractional ns |
| local_ts | input | TS_W (40) | Local capture timestamp, fractional ns |
| gain_en | input | 2 | Bit 0 enables the proportional path; bit 1 enables the integral path |
| coarse_shift | input | 4 | Right-shift amount for the proportional path |
| fine_shift | input | 4 | Right-shift amount for the integral path |
| adj_valid | output | 1 | Pulse marking a new correction |
| adj_value | output | ACC_W+1 (49) | Signed increment correction |

## Verification
The bench drives the integral register into both saturation limits with long runs of extreme errors. A design that wraps would show a sudden sign flip in the correction. Error pairs whose difference crosses the 2^TS_W boundary check that the subtraction is read as signed. A logical shift would turn small negative errors into huge positive ones. Toggling the integral enable between Syncs checks that the sum restarts from zero rather than from a stale value. The bench also checks that the output includes the current sample and does not lag one Sync behind.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;
    localparam int SHIFT_W = 4;

    typedef struct packed {
        logic               coarse_en;
        logic               fine_en;
        logic [SHIFT_W-1:0] coarse_shift;
        logic [SHIFT_W-1:0] fine_shift;
    } servo_cfg_t;

    function automatic servo_cfg_t make_cfg(input logic [1:0] en,
                                            input logic [SHIFT_W-1:0] cs,
                                            input logic [SHIFT_W-1:0] fs);
        servo_cfg_t c;
        c.coarse_en    = en[0];
        c.fine_en      = en[1];
        c.coarse_shift = cs;
        c.fine_shift   = fs;
        return c;
    endfunction
endpackage

// File: rtl/ptp_phase_error.sv
module ptp_phase_error #(
    parameter int TS_W = 40
) (
    input  logic [TS_W-1:0]        host_ts,
    input  logic [TS_W-1:0]        local_ts,
    output logic signed [TS_W-1:0] phase_err
);
    // Modular difference read as signed (R1)
    always_comb begin
        phase_err = $signed(host_ts - local_ts);
    end
endmodule

// File: rtl/ptp_prop_path.sv
module ptp_prop_path
    import ptp_servo_pkg::*;
#(
    parameter int TS_W  = 40,
    parameter int ADJ_W = 49
) (
    input  logic                    enable,
    input  logic [SHIFT_W-1:0]      shift,
    input  logic signed [TS_W-1:0]  phase_err,
    output logic signed [ADJ_W-1:0] prop_term
);
    logic signed [TS_W-1:0] shifted;

    always_comb begin
        shifted   = phase_err >>> shift;
        prop_term = enable ? {{(ADJ_W-TS_W){shifted[TS_W-1]}}, shifted} : '0;
    end
endmodule

// File: rtl/ptp_integrator.sv
module ptp_integrator
    import ptp_servo_pkg::*;
#(
    parameter int TS_W  = 40,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    sample_valid,
    input  logic [SHIFT_W-1:0]      shift,
    input  logic signed [TS_W-1:0]  phase_err,
    output logic signed [ACC_W-1:0] acc_next,
    output logic signed [ACC_W-1:0] acc_q
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [TS_W-1:0]  inc;
    logic signed [ACC_W:0]   wide_sum;

    always_comb begin
        inc      = phase_err >>> shift;
        wide_sum = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-TS_W){inc[TS_W-1]}}, inc};
        if (!enable) begin
            acc_next = '0;
        end else if (!sample_valid) begin
            acc_next = acc_q;
        end else if (wide_sum[ACC_W] != wide_sum[ACC_W-1]) begin
            acc_next = wide_sum[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_next = wide_sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_next;
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (acc_q == '0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && sample_valid && acc_q == ACC_MAX && !phase_err[TS_W-1]) |=> (acc_q == ACC_MAX));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && sample_valid && acc_q == ACC_MIN && phase_err[TS_W-1]) |=> (acc_q == ACC_MIN));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && !sample_valid) |=> $stable(acc_q));
endmodule

// File: rtl/ptp_freq_servo.sv
module ptp_freq_servo
    import ptp_servo_pkg::*;
#(
    parameter int TS_W  = 40,
    parameter int ACC_W = 48,
    localparam int ADJ_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync_valid,
    input  logic [TS_W-1:0]         host_ts,
    input  logic [TS_W-1:0]         local_ts,
    input  logic [1:0]              gain_en,
    input  logic [SHIFT_W-1:0]      coarse_shift,
    input  logic [SHIFT_W-1:0]      fine_shift,
    output logic                    adj_valid,
    output logic signed [ADJ_W-1:0] adj_value
);
    servo_cfg_t              cfg;
    logic signed [TS_W-1:0]  phase_err;
    logic signed [ADJ_W-1:0] prop_term;
    logic signed [ACC_W-1:0] acc_next;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ADJ_W-1:0] sum_d;

    assign cfg = make_cfg(gain_en, coarse_shift, fine_shift);

    ptp_phase_error #(.TS_W(TS_W)) u_err (
        .host_ts  (host_ts),
        .local_ts (local_ts),
        .phase_err(phase_err)
    );

    ptp_prop_path #(.TS_W(TS_W), .ADJ_W(ADJ_W)) u_prop (
        .enable   (cfg.coarse_en),
        .shift    (cfg.coarse_shift),
        .phase_err(phase_err),
        .prop_term(prop_term)
    );

    ptp_integrator #(.TS_W(TS_W), .ACC_W(ACC_W)) u_int (
        .clk         (clk),
        .rst         (rst),
        .enable      (cfg.fine_en),
        .sample_valid(sync_valid),
        .shift       (cfg.fine_shift),
        .phase_err   (phase_err),
        .acc_next    (acc_next),
        .acc_q       (acc_q)
    );

    always_comb begin
        sum_d = prop_term + {acc_next[ACC_W-1], acc_next};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adj_valid <= 1'b0;
            adj_value <= '0;
        end else begin
            adj_valid <= sync_valid;
            if (sync_valid) adj_value <= sum_d;
        end
    end

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        sync_valid |=> adj_valid);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !sync_valid |=> !adj_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !sync_valid |=> $stable(adj_value));

    assert_integral_used_R4: assert property (@(posedge clk) disable iff (rst)
        (sync_valid && !cfg.coarse_en) |=> (adj_value == {acc_q[ACC_W-1], acc_q}));
endmodule

// File: tb/tb_ptp_freq_servo.sv
`timescale 1ns/1ps
module tb_ptp_freq_servo;
    localparam int TS_W  = 40;
    localparam int ACC_W = 48;
    localparam int ADJ_W = ACC_W + 1;
    localparam longint ACC_MAX = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< (ACC_W-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_valid = 1'b0;
    logic [TS_W-1:0] host_ts = '0;
    logic [TS_W-1:0] local_ts = '0;
    logic [1:0] gain_en = 2'b00;
    logic [3:0] coarse_shift = '0;
    logic [3:0] fine_shift = '0;
    logic adj_valid;
    logic signed [ADJ_W-1:0] adj_value;

    int tests = 0;
    int fails = 0;
    longint m_acc = 0;
    longint m_out = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ptp_freq_servo #(.TS_W(TS_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst(rst), .sync_valid(sync_valid),
        .host_ts(host_ts), .local_ts(local_ts), .gain_en(gain_en),
        .coarse_shift(coarse_shift), .fine_shift(fine_shift),
        .adj_valid(adj_valid), .adj_value(adj_value)
    );

    task automatic check(input string req, input longint got, input longint exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint err_of(input logic [TS_W-1:0] h, input logic [TS_W-1:0] l);
        logic signed [TS_W-1:0] d;
        d = $signed(h - l);
        return longint'(d);
    endfunction

    function automatic longint clamp(input longint v);
        if (v > ACC_MAX) return ACC_MAX;
        if (v < ACC_MIN) return ACC_MIN;
        return v;
    endfunction

    task automatic set_gain(input logic [1:0] en, input logic [3:0] cs, input logic [3:0] fs);
        @(negedge clk);
        gain_en = en; coarse_shift = cs; fine_shift = fs;
        @(negedge clk);
        if (!en[1]) m_acc = 0;
    endtask

    task automatic do_sync(input logic [TS_W-1:0] h, input logic [TS_W-1:0] l,
                           input string req, input bit chk_now);
        longint e;
        longint p;
        @(negedge clk);
        host_ts = h; local_ts = l; sync_valid = 1'b1;
        e = err_of(h, l);
        p = gain_en[0] ? (e >>> coarse_shift) : 0;
        if (gain_en[1]) m_acc = clamp(m_acc + (e >>> fine_shift));
        else            m_acc = 0;
        m_out = p + m_acc;
        @(negedge clk);
        sync_valid = 1'b0;
        if (chk_now) begin
            check({req, " valid"}, longint'(adj_valid), 1);
            check(req, longint'(adj_value), m_out);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", longint'(adj_valid), 0);
        check("R9 reset value", longint'(adj_value), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after release", longint'(adj_value), 0);

        // R10: all paths disabled
        do_sync(40'd5000, 40'd1000, "R10 gain off", 1);

        // R1/R2: proportional only, positive and wrapped negative errors
        set_gain(2'b01, 4'd2, 4'd0);
        do_sync(40'd1000, 40'd100, "R2 coarse pos", 1);
        do_sync(40'd5, 40'd10, "R1 coarse neg", 1);           // -5 >>> 2 = -2
        do_sync(40'd3, {TS_W{1'b1}}, "R1 wrap pos", 1);      // 3 - (2^40-1) = +4
        do_sync(40'd0, 40'd1, "R2 floor neg", 1);            // -1 >>> 2 = -1

        // R7: pulse is one cycle wide
        @(negedge clk);
        check("R7 pulse width", longint'(adj_valid), 0);
        // R8: value held without Sync
        repeat (4) @(negedge clk);
        check("R8 hold", longint'(adj_value), m_out);

        // R3: integral only, accumulation across samples
        set_gain(2'b10, 4'd0, 4'd1);
        do_sync(40'd100, 40'd0, "R3 acc 1", 1);
        do_sync(40'd100, 40'd0, "R3 acc 2", 1);
        do_sync(40'd0, 40'd30, "R3 acc 3", 1);

        // R4: both paths
        set_gain(2'b11, 4'd3, 4'd2);
        do_sync(40'd800, 40'd0, "R4 sum 1", 1);
        do_sync(40'd0, 40'd400, "R4 sum 2", 1);

        // R6: disable clears, re-enable restarts from zero
        set_gain(2'b00, 4'd3, 4'd2);
        set_gain(2'b10, 4'd3, 4'd0);
        do_sync(40'd7, 40'd0, "R6 restart", 1);

        // R5: positive saturation
        set_gain(2'b10, 4'd0, 4'd0);
        for (int i = 0; i < 300; i++)
            do_sync({1'b0, {(TS_W-1){1'b1}}}, 40'd0, "R5 sat pos", (i % 50) == 49);
        check("R5 at max", longint'(adj_value), ACC_MAX);
        // R5: negative saturation
        for (int i = 0; i < 600; i++)
            do_sync({1'b1, {(TS_W-1){1'b0}}}, 40'd0, "R5 sat neg", (i % 100) == 99);
        check("R5 at min", longint'(adj_value), ACC_MIN);

        // Random mix: R1-related wrap, R2, R3, R4, R5, R6
        set_gain(2'b00, 4'd0, 4'd0);
        for (int i = 0; i < 400; i++) begin
            logic [TS_W-1:0] h;
            logic [TS_W-1:0] l;
            if ((i % 40) == 0)
                set_gain(2'($urandom), 4'($urandom), 4'($urandom));
            h = {8'($urandom), 32'($urandom)};
            if ($urandom % 2) l = h - TS_W'($urandom % 100000);
            else              l = {8'($urandom), 32'($urandom)};
            do_sync(h, l, "R4 random", 1);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule